// File: doc/BRIEF.md
# Converter Result Debounce Filter

This block sits between an analog-to-digital converter and the status byte that software reads. Each finished conversion arrives as a result word with a one-cycle done strobe. The block decides whether that word is copied into the status register. A bypass control selects one of two modes. With the bypass set, every conversion is copied. With the bypass clear, a value is only published once the same upper bits have been seen on a run of consecutive conversions. This keeps the reported reading steady when the analog input is noisy.

Along with the result, the block receives the converter's source-select bit: 0 for the on-die temperature sensor, 1 for the external sense pin. The block does not act on this bit as a mux control. It uses it as a tag: whenever the source or the bypass bit changes, the run of agreeing conversions starts again from nothing. Each load of the status register is marked by a single-cycle pulse.

Top module: `adc_result_filter`

## Requirements
- R1: During and after synchronous reset, the status output is zero and the load pulse is low until a conversion loads the register.
- R2: With the bypass input at 1, every conversion strobe loads the full result into the status output. The new value and a load pulse appear in the cycle after the strobe.
- R3: With the bypass input at 0 (the state after reset), the status output is loaded only in the cycle after the fourth consecutive conversion whose upper six bits agree. The first three conversions of such a run leave the status unchanged and produce no pulse.
- R4: Only the upper six bits (result bits 7 down to 2) take part in the comparison. The value loaded is the full 8-bit result of the conversion that completes the run.
- R5: A conversion whose upper six bits differ from the current candidate becomes the new candidate with a run length of one. After that it needs three more agreeing conversions before a load.
- R6: In filtered mode, once a run has reached four, every further agreeing conversion loads the status register again.
- R7: A change of the source-select input restarts the run. A conversion in the cycle of the change counts as the first of a new run.
- R8: A change of the bypass input restarts the run in the same way.
- R9: The load pulse is high for exactly the cycles in which the status output took a new value. With no conversion strobe, the status output holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done | input | 1 | One-cycle strobe: a conversion result is valid |
| conv_result | input | 8 | Result word of the finished conversion |
| filter_bypass | input | 1 | 1: load on every conversion; 0: debounce |
| src_sel | input | 1 | Converter source tag: 0 internal sensor, 1 external pin |
| status_q | output | 8 | Published status value |
| status_load | output | 1 | High for one cycle when status_q was loaded |

## Verification
The bench builds the block with its defaults: 8-bit results, six compared bits and a run length of four. At that size, every 8-bit result can be pushed through the bypass path. It also makes every one of the 64 upper-bit patterns go through a full four-conversion run, with the lower two bits different on each conversion. A reference model in the bench then follows a pseudo-random stream drawn from a small alphabet of values. In that stream, matches, mismatches, idle cycles and toggles of source and bypass mix freely. Directed sequences cover a restart by a new candidate, runs longer than four, and the clearing effect of each control input.

// File: rtl/afl_pkg.sv
package afl_pkg;

    // Snapshot of the control inputs that restart a run when they change.
    typedef struct packed {
        logic bypass;
        logic src;
    } afl_cfg_t;

    // What happens to the status register in a given cycle.
    typedef enum logic [1:0] {
        ACT_HOLD     = 2'd0,
        ACT_BYPASS   = 2'd1,
        ACT_FILTERED = 2'd2
    } afl_act_e;

    // Saturating increment toward a limit.
    function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
        return (v >= lim) ? lim : v + 1;
    endfunction

endpackage

// File: rtl/afl_cfg_watch.sv
module afl_cfg_watch
    import afl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  afl_cfg_t cfg_i,
    output logic     changed_o
);

    afl_cfg_t cfg_prev;

    always_ff @(posedge clk) begin
        if (rst) cfg_prev <= '0;
        else     cfg_prev <= cfg_i;
    end

    assign changed_o = (cfg_prev != cfg_i);

endmodule

// File: rtl/afl_run_counter.sv
module afl_run_counter
    import afl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CMP_W   = 6,
    parameter int MATCH_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] result,
    input  logic              bypass,
    input  logic              restart,
    output logic              fire_o
);

    localparam int CNT_W = $clog2(MATCH_N + 1);

    logic [CMP_W-1:0] cand_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_eff;
    logic [CNT_W-1:0] run_d;
    logic [CMP_W-1:0] cand_d;
    logic [CMP_W-1:0] upper;

    assign upper   = result[DATA_W-1 -: CMP_W];
    assign run_eff = restart ? '0 : run_q;

    always_comb begin
        run_d  = run_eff;
        cand_d = cand_q;
        if (bypass) begin
            run_d = '0;
        end else if (conv_done) begin
            if (run_eff == '0 || upper != cand_q) begin
                cand_d = upper;
                run_d  = CNT_W'(1);
            end else begin
                run_d = CNT_W'(sat_inc(int'(run_eff), MATCH_N));
            end
        end
    end

    assign fire_o = conv_done && !bypass && (run_d == CNT_W'(MATCH_N));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            cand_q <= '0;
        end else begin
            run_q  <= run_d;
            cand_q <= cand_d;
        end
    end

    // R6: run length saturates at the match count
    a_r6_run_bounded: assert property (@(posedge clk) disable iff (rst)
        run_q <= CNT_W'(MATCH_N));

    // R5: a differing conversion starts a new run of one
    a_r5_new_candidate: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !bypass && !restart && run_q != '0 && upper != cand_q)
        |=> (run_q == CNT_W'(1)));

endmodule

// File: rtl/afl_status_reg.sv
module afl_status_reg
    import afl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  afl_act_e          act_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] status_q,
    output logic              status_load
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q    <= '0;
            status_load <= 1'b0;
        end else begin
            status_load <= (act_i != ACT_HOLD);
            if (act_i != ACT_HOLD) status_q <= data_i;
        end
    end

    // R9: no pulse means the register held
    a_r9_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !status_load |-> $stable(status_q));

endmodule

// File: rtl/adc_result_filter.sv
module adc_result_filter
    import afl_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CMP_W   = 6,
    parameter int MATCH_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    input  logic              filter_bypass,
    input  logic              src_sel,
    output logic [DATA_W-1:0] status_q,
    output logic              status_load
);

    afl_cfg_t cfg;
    logic     cfg_changed;
    logic     fire;
    afl_act_e act;

    assign cfg.bypass = filter_bypass;
    assign cfg.src    = src_sel;

    afl_cfg_watch u_watch (
        .clk       (clk),
        .rst       (rst),
        .cfg_i     (cfg),
        .changed_o (cfg_changed)
    );

    afl_run_counter #(
        .DATA_W  (DATA_W),
        .CMP_W   (CMP_W),
        .MATCH_N (MATCH_N)
    ) u_run (
        .clk       (clk),
        .rst       (rst),
        .conv_done (conv_done),
        .result    (conv_result),
        .bypass    (filter_bypass),
        .restart   (cfg_changed),
        .fire_o    (fire)
    );

    always_comb begin
        if (conv_done && filter_bypass) act = ACT_BYPASS;
        else if (fire)                  act = ACT_FILTERED;
        else                            act = ACT_HOLD;
    end

    afl_status_reg #(
        .DATA_W (DATA_W)
    ) u_status (
        .clk         (clk),
        .rst         (rst),
        .act_i       (act),
        .data_i      (conv_result),
        .status_q    (status_q),
        .status_load (status_load)
    );

    // R2: bypass loads the full result in the following cycle
    a_r2_bypass_loads: assert property (@(posedge clk) disable iff (rst)
        (conv_done && filter_bypass) |=> (status_load && status_q == $past(conv_result)));

    // R9: a load pulse always follows a conversion strobe
    a_r9_load_needs_done: assert property (@(posedge clk) disable iff (rst)
        $rose(status_load) |-> $past(conv_done));

    // R1: reset leaves no pulse behind
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !status_load);

endmodule

// File: tb/tb_adc_result_filter.sv
module tb_adc_result_filter;

    localparam int    DATA_W = 8;
    localparam int    CMP_W  = 6;
    localparam int    RUN_N  = 4;
    localparam time   CLK_P  = 20ns;

    logic              clk = 1'b0;
    logic              rst;
    logic              conv_done;
    logic [DATA_W-1:0] conv_result;
    logic              filter_bypass;
    logic              src_sel;
    logic [DATA_W-1:0] status_q;
    logic              status_load;

    int n_vec  = 0;
    int n_fail = 0;

    // reference state
    logic [DATA_W-1:0] m_status;
    logic              m_load;
    logic [CMP_W-1:0]  m_cand;
    int                m_run;
    logic              m_prev_fo;
    logic              m_prev_sel;

    always #(CLK_P/2) clk = ~clk;

    adc_result_filter #(.DATA_W(DATA_W), .CMP_W(CMP_W), .MATCH_N(RUN_N)) dut (
        .clk           (clk),
        .rst           (rst),
        .conv_done     (conv_done),
        .conv_result   (conv_result),
        .filter_bypass (filter_bypass),
        .src_sel       (src_sel),
        .status_q      (status_q),
        .status_load   (status_load)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    task automatic check(string tag);
        n_vec++;
        if (status_q !== m_status || status_load !== m_load) begin
            n_fail++;
            $display("FAIL %s: status=%02h load=%0b expected status=%02h load=%0b",
                     tag, status_q, status_load, m_status, m_load);
        end
    endtask

    // One cycle: drive after the falling edge, check at the next falling edge.
    task automatic step(input logic d, input logic [DATA_W-1:0] r,
                        input logic fo, input logic sel, input string tag);
        conv_done     = d;
        conv_result   = r;
        filter_bypass = fo;
        src_sel       = sel;
        m_load = 1'b0;
        if (fo != m_prev_fo || sel != m_prev_sel) m_run = 0;
        if (fo) begin
            m_run = 0;
            if (d) begin m_status = r; m_load = 1'b1; end
        end else if (d) begin
            if (m_run == 0 || r[DATA_W-1:DATA_W-CMP_W] != m_cand) begin
                m_cand = r[DATA_W-1:DATA_W-CMP_W];
                m_run  = 1;
            end else if (m_run < RUN_N) begin
                m_run = m_run + 1;
            end
            if (m_run == RUN_N) begin m_status = r; m_load = 1'b1; end
        end
        m_prev_fo  = fo;
        m_prev_sel = sel;
        @(negedge clk);
        check(tag);
    endtask

    task automatic expect_load(logic exp, string tag);
        n_vec++;
        if (status_load !== exp) begin
            n_fail++;
            $display("FAIL %s: load=%0b expected %0b", tag, status_load, exp);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; conv_done = 1'b0; conv_result = '0;
        filter_bypass = 1'b0; src_sel = 1'b0;
        m_status = '0; m_load = 1'b0; m_cand = '0; m_run = 0;
        m_prev_fo = 1'b0; m_prev_sel = 1'b0;
        repeat (3) @(negedge clk);
        check("R1");
        rst = 1'b0;
        @(negedge clk);
        check("R1");

        // R2: every result through the bypass path
        for (int v = 0; v < 256; v++) step(1'b1, 8'(v), 1'b1, 1'b0, "R2");
        step(1'b0, 8'h00, 1'b1, 1'b0, "R9");

        // R3/R4: every upper pattern, lower bits differ each time, R7 restart between
        for (int u = 0; u < 64; u++) begin
            for (int k = 0; k < 4; k++) begin
                step(1'b1, {6'(u), 2'(k + u)}, 1'b0, u[0], "R4");
                expect_load(k == 3, "R3");
            end
        end

        // R5: three of A then four of B
        step(1'b0, 8'h00, 1'b0, 1'b1, "R7");
        for (int i = 0; i < 3; i++) step(1'b1, 8'h40, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 8'h81, 1'b0, 1'b0, "R5");
            expect_load(i == 3, "R5");
        end

        // R6: long run keeps loading
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 8'h80 | 8'(i), 1'b0, 1'b0, "R6");
            expect_load(1'b1, "R6");
        end
        for (int i = 0; i < 5; i++) step(1'b0, 8'hFF, 1'b0, 1'b0, "R9");

        // R7: a source change in mid-run
        step(1'b1, 8'h20, 1'b0, 1'b0, "R7");
        step(1'b1, 8'h20, 1'b0, 1'b0, "R7");
        step(1'b1, 8'h20, 1'b0, 1'b1, "R7");
        step(1'b1, 8'h20, 1'b0, 1'b1, "R7");
        expect_load(1'b0, "R7");

        // R8: a bypass blip in mid-run
        step(1'b1, 8'h30, 1'b0, 1'b1, "R8");
        step(1'b1, 8'h30, 1'b0, 1'b1, "R8");
        step(1'b0, 8'h30, 1'b1, 1'b1, "R8");
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 8'h31, 1'b0, 1'b1, "R8");
            expect_load(1'b0, "R8");
        end
        step(1'b1, 8'h32, 1'b0, 1'b1, "R8");
        expect_load(1'b1, "R8");

        // Mixed stream against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            logic d, fo, sel;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d   = lfsr[0] | lfsr[1];
            fo  = (lfsr[7:3] == 5'd0) ? ~filter_bypass : filter_bypass;
            sel = (lfsr[12:8] == 5'd1) ? ~src_sel : src_sel;
            step(d, {lfsr[2] ? 6'h15 : 6'h2A, lfsr[15:14]}, fo, sel, "R3");
        end

        finish_run();
    end

endmodule